// File: doc/BRIEF.md
# Word-Boundary Priority Word Inserter

This block sits in a 32-bit transmit stream, after the stage that wraps packets and before the stage that narrows words to bytes. It merges three word sources into one output stream under a fixed precedence. The first source is a short acknowledgment sequence, started by a one-cycle request strobe. The second is an idle word. The third is ordinary packet data from upstream. Every insertion falls between whole words, so a packet word is never split.

Idle words come from two causes. A word counter forces one at a bounded interval, so the receiver can keep its alignment. The block also sends an idle whenever upstream has nothing valid to offer, and that idle restarts the interval. An acknowledgment sequence, once begun, always runs to its end before any other word, so an idle never lands inside one.

Both stream interfaces are valid/ready. Upstream words move only when `s_valid` and `s_ready` are both high at a clock edge. While an inserted word is being produced, `s_ready` stays low, so packet words wait and are never dropped. On the output side, a word that is held by `m_ready` low stays unchanged until it is taken. From the first cycle after reset the output always carries a word, so the link is never left empty.

Top module: `txw_prio_insert`

## Requirements
- R1: While `rst_n` is low, `m_valid` and `s_ready` are both 0.
- R2: If `m_valid` is 1 and `m_ready` is 0, then in the next cycle `m_valid` is still 1 and `m_data` is unchanged.
- R3: Packet words accepted upstream (`s_valid && s_ready`) leave on `m_data` in the same order, each exactly once. `s_ready` is high only in a cycle in which the output register is free (empty, or being taken).
- R4: Precedence at each word boundary is: acknowledgment word, then a due idle, then a packet word. An acknowledgment that is pending when an idle falls due is sent in full first, and the idle follows straight after it.
- R5: An acknowledgment sequence is ACK_LEN consecutive output words, ACK_WORDS word 0 first (default 32'h7C7C7C7C, 32'h06060606, 32'h60606060). Nothing else, idle included, comes between them.
- R6: Each clock cycle with `ack_stb` high counts as one request, and each request yields exactly one sequence. This holds for requests that arrive while a sequence is in flight, with up to 2^PEND_W-1 requests waiting. The first word of a sequence is loaded at the second clock edge after the strobe cycle.
- R7: The idle word is IDLE_WORD (default 32'hB53C3CBC). After REQ_AT = PERIOD - 2*ACK_LEN non-idle words with no idle between them, the next free word boundary that has no acknowledgment pending carries an idle. Packet words that are waiting do not delay it.
- R8: While no more than one acknowledgment request is waiting, no run of non-idle output words between two idles is longer than PERIOD-1 (default 9999).
- R9: When `s_valid` is low and nothing is pending, the next output word is an idle. Any idle sent restarts the interval count.
- R10: Once `m_valid` has risen after reset, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_stb | input | 1 | Acknowledgment request, one request per high cycle |
| s_data | input | DATA_W | Upstream packet word |
| s_valid | input | 1 | Upstream word valid |
| s_ready | output | 1 | Upstream word accepted this cycle |
| m_data | output | DATA_W | Output word |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream takes the output word |

## Verification
The hardest case to reach is an acknowledgment that becomes pending in the same cycle the periodic idle falls due. It only arises after nearly ten thousand unbroken non-idle words. The stimulus keeps the upstream valid and the downstream ready without a break, so the word count can be known exactly. It then times the strobe from the observed run length, so the request is latched just as the count reaches its threshold. The bench then expects the three acknowledgment words and, right after them, an idle with a run length of exactly REQ_AT + ACK_LEN. A second uninterrupted stretch confirms that periodic idles arrive after exactly REQ_AT packet words, with packets waiting throughout.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [1:0] {
    SRC_PKT  = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_ACK  = 2'd2
  } src_e;
endpackage

// File: rtl/txw_idle_sched.sv
// Counts non-idle words emitted since the last idle; the due flag stays set
// until an idle actually goes out.
module txw_idle_sched
  import txw_pkg::*;
#(
  parameter int PERIOD = 10000,
  parameter int REQ_AT = 9994
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  src_e emit_src,
  output logic idle_due
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(REQ_AT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (emit) begin
      if (emit_src == SRC_IDLE) begin
        cnt_q <= '0;
      end else if (cnt_q < LIMIT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idle_due = (cnt_q >= LIMIT);
endmodule

// File: rtl/txw_ack_seq.sv
// Latches acknowledgment requests and steps through the fixed word sequence.
module txw_ack_seq
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACK_LEN = 3,
  parameter int PEND_W = 2,
  parameter logic [ACK_LEN*DATA_W-1:0] ACK_WORDS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_stb,
  input  logic              emit,
  input  src_e              emit_src,
  output logic              ack_busy,
  output logic [DATA_W-1:0] ack_word
);
  localparam int IW = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(ACK_LEN - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [DATA_W-1:0] word_tbl [ACK_LEN];
  logic [IW-1:0]     idx_q;
  logic [PEND_W-1:0] pend_q;
  logic              ack_emit, seq_start, pend_inc;

  for (genvar g = 0; g < ACK_LEN; g++) begin : g_tbl
    assign word_tbl[g] = ACK_WORDS[g*DATA_W +: DATA_W];
  end

  assign ack_emit  = emit && (emit_src == SRC_ACK);
  assign seq_start = ack_emit && (idx_q == '0);
  assign pend_inc  = ack_stb && ((pend_q != PEND_MAX) || seq_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      idx_q  <= '0;
    end else begin
      pend_q <= pend_q + PEND_W'(pend_inc) - PEND_W'(seq_start);
      if (ack_emit) begin
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign ack_busy = (pend_q != '0) || (idx_q != '0);
  assign ack_word = word_tbl[idx_q];
endmodule

// File: rtl/txw_word_sel.sv
// Fixed-precedence choice of the next output word.
module txw_word_sel
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
  input  logic              ack_busy,
  input  logic              idle_due,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic [DATA_W-1:0] ack_word,
  output src_e              sel,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    if (ack_busy) begin
      sel  = SRC_ACK;
      word = ack_word;
    end else if (idle_due) begin
      sel  = SRC_IDLE;
      word = IDLE_WORD;
    end else if (s_valid) begin
      sel  = SRC_PKT;
      word = s_data;
    end else begin
      sel  = SRC_IDLE;
      word = IDLE_WORD;
    end
  end
endmodule

// File: rtl/txw_prio_insert.sv
module txw_prio_insert
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PERIOD = 10000,
  parameter int ACK_LEN = 3,
  parameter int PEND_W = 2,
  parameter logic [DATA_W-1:0] IDLE_WORD = 32'hB53C3CBC,
  parameter logic [ACK_LEN*DATA_W-1:0] ACK_WORDS =
    {32'h60606060, 32'h06060606, 32'h7C7C7C7C}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_stb,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready
);
  // Margin leaves room for one sequence in flight plus one waiting.
  localparam int REQ_AT = PERIOD - 2 * ACK_LEN;

  logic              load;
  logic              ack_busy;
  logic              idle_due;
  logic [DATA_W-1:0] ack_word;
  logic [DATA_W-1:0] next_word;
  src_e              sel;

  assign load = !m_valid || m_ready;

  txw_idle_sched #(
    .PERIOD(PERIOD),
    .REQ_AT(REQ_AT)
  ) u_idle (
    .clk(clk),
    .rst_n(rst_n),
    .emit(load),
    .emit_src(sel),
    .idle_due(idle_due)
  );

  txw_ack_seq #(
    .DATA_W(DATA_W),
    .ACK_LEN(ACK_LEN),
    .PEND_W(PEND_W),
    .ACK_WORDS(ACK_WORDS)
  ) u_ack (
    .clk(clk),
    .rst_n(rst_n),
    .ack_stb(ack_stb),
    .emit(load),
    .emit_src(sel),
    .ack_busy(ack_busy),
    .ack_word(ack_word)
  );

  txw_word_sel #(
    .DATA_W(DATA_W),
    .IDLE_WORD(IDLE_WORD)
  ) u_sel (
    .ack_busy(ack_busy),
    .idle_due(idle_due),
    .s_valid(s_valid),
    .s_data(s_data),
    .ack_word(ack_word),
    .sel(sel),
    .word(next_word)
  );

  assign s_ready = rst_n && load && (sel == SRC_PKT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= next_word;
    end
  end
endmodule

// File: rtl/txw_prio_insert_chk.sv
module txw_prio_insert_chk #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] s_data,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              m_valid,
  input logic              m_ready,
  input logic              ack_busy,
  input logic              idle_due
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!s_ready);
    end
  end

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  a_r3_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!m_valid || m_ready));

  a_r3_pkt_forward: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_data == $past(s_data));

  a_r4_ack_blocks_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |-> !s_ready);

  a_r5_no_idle_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy && (!m_valid || m_ready) |=> m_data != IDLE_WORD);

  a_r7_due_idle_sent: assert property (@(posedge clk) disable iff (!rst_n)
    idle_due && !ack_busy && (!m_valid || m_ready) |=> m_data == IDLE_WORD);

  a_r9_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && !ack_busy && (!m_valid || m_ready) |=> m_valid && m_data == IDLE_WORD);

  a_r10_valid_stays: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> m_valid);
endmodule

bind txw_prio_insert txw_prio_insert_chk #(
  .DATA_W(DATA_W),
  .IDLE_WORD(IDLE_WORD)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .s_data(s_data),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .m_data(m_data),
  .m_valid(m_valid),
  .m_ready(m_ready),
  .ack_busy(ack_busy),
  .idle_due(idle_due)
);

// File: tb/test_txw_prio_insert.sv
module test_txw_prio_insert;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 10000;
  localparam int ACK_LEN = 3;
  localparam int REQ_AT = PERIOD - 2 * ACK_LEN;
  localparam logic [31:0] IDLE_W = 32'hB53C3CBC;
  localparam logic [31:0] ACKW [ACK_LEN] = '{32'h7C7C7C7C, 32'h06060606, 32'h60606060};

  logic        clk, rst_n, ack_stb;
  logic [31:0] s_data, m_data;
  logic        s_valid, s_ready, m_valid, m_ready;

  txw_prio_insert i_txw_prio_insert (
    .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  int  run = 0, last_run = 0, n_idle = 0, ack_pos = 0, ack_done = 0, ack_req = 0;
  int  pkt_left = 0, gap_pct = 0, seq = 0;
  bit  strict = 0, rdy_rand = 0, up_acc = 0, hold_prev = 0;
  int  strict_idles = 0;
  logic [31:0] held = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ack_index(input logic [31:0] d);
    for (int k = 0; k < ACK_LEN; k++) if (d == ACKW[k]) return k;
    return -1;
  endfunction

  // Driver: changes inputs one time unit after each rising edge.
  initial begin
    s_valid = 1'b0; s_data = '0; m_ready = 1'b1; ack_stb = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      if (up_acc) begin
        seq++;
        if (pkt_left > 0) pkt_left--;
        s_valid = 1'b0;
      end
      if (!s_valid && pkt_left > 0 && int'(lfsr % 100) >= gap_pct) begin
        s_valid = 1'b1;
        s_data  = {8'hA5, 24'(seq)};
      end
      m_ready = rdy_rand ? (lfsr[3] | lfsr[9]) : 1'b1;
    end
  end

  // Monitor / scoreboard: samples at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      up_acc = 0;
      if (rst_n) begin
        if (hold_prev)
          check(m_valid && m_data == held, "R2", "held word changed", m_data, held);
        if (m_valid && m_ready) begin
          if (m_data == IDLE_W) begin
            check(ack_pos == 0, "R5", "idle inside ack sequence", 32'(ack_pos), 0);
            check(run <= PERIOD - 1, "R8", "non-idle run too long", 32'(run), PERIOD - 1);
            if (strict && run > 0)
              check(run == REQ_AT, "R7", "periodic idle spacing", 32'(run), REQ_AT);
            if (strict) strict_idles++;
            last_run = run; run = 0; n_idle++;
          end else if (ack_index(m_data) >= 0) begin
            check(ack_index(m_data) == ack_pos, "R5", "ack word order",
                  32'(ack_index(m_data)), 32'(ack_pos));
            if (ack_pos == ACK_LEN - 1) begin ack_pos = 0; ack_done++; end
            else ack_pos++;
            run++;
          end else begin
            check(ack_pos == 0, "R5", "packet inside ack sequence", 32'(ack_pos), 0);
            if (exp_q.size() == 0) check(0, "R3", "unexpected packet word", m_data, 0);
            else begin
              logic [31:0] e;
              e = exp_q.pop_front();
              check(m_data == e, "R3", "packet order", m_data, e);
            end
            run++;
          end
        end
        hold_prev = m_valid && !m_ready;
        held = m_data;
        if (s_valid && s_ready) begin
          exp_q.push_back(s_data);
          up_acc = 1;
        end
      end
    end
  end

  task automatic pulse_ack(input int cycles);
    @(posedge clk); #1;
    ack_stb = 1'b1;
    repeat (cycles) @(posedge clk);
    #1; ack_stb = 1'b0;
    ack_req += cycles;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_valid, "R1", "m_valid in reset", 32'(m_valid), 0);
    check(!s_ready, "R1", "s_ready in reset", 32'(s_ready), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(m_valid && m_data == IDLE_W, "R9", "fill idle after reset", m_data, IDLE_W);
    repeat (5) @(negedge clk);
    check(m_valid, "R10", "valid stays after reset", 32'(m_valid), 1);

    // Unbroken stream: periodic idle every REQ_AT words (R7, R9 restart, R4 idle over packet)
    strict = 1; gap_pct = 0; rdy_rand = 0; pkt_left = 40000;
    while (strict_idles < 3) @(posedge clk);
    strict = 0;
    check(n_idle > 2, "R7", "periodic idles seen", 32'(strict_idles), 3);

    // Ack latched just as the idle falls due (R4, R6)
    forever begin
      @(posedge clk);
      if (run == REQ_AT - 2) break;
    end
    #1; ack_stb = 1'b1;
    @(posedge clk); #1; ack_stb = 1'b0; ack_req++;
    @(posedge clk); @(negedge clk);
    check(m_data == ACKW[0], "R6", "ack word 0 two edges after strobe", m_data, ACKW[0]);
    n0 = n_idle;
    while (n_idle == n0) @(posedge clk);
    check(last_run == REQ_AT + ACK_LEN, "R4", "ack sent before due idle",
          32'(last_run), REQ_AT + ACK_LEN);

    // Random backpressure and gaps with overlapping ack requests (R2, R3, R6)
    pkt_left = 3000; gap_pct = 30; rdy_rand = 1;
    for (int i = 0; i < 30; i++) begin
      repeat (20 + int'(lfsr % 50)) @(posedge clk);
      if (i == 5) pulse_ack(2);
      else if (i == 9) begin pulse_ack(1); repeat (2) @(posedge clk); pulse_ack(1); end
      else pulse_ack(1);
    end
    while (pkt_left > 0) @(posedge clk);

    // Drain, then upstream silent: only fill idles (R9)
    rdy_rand = 0;
    repeat (60) @(posedge clk);
    check(exp_q.size() == 0, "R3", "packet words lost", 32'(exp_q.size()), 0);
    check(ack_done == ack_req, "R6", "ack sequences per request", 32'(ack_done), 32'(ack_req));
    check(ack_pos == 0, "R5", "ack sequence left open", 32'(ack_pos), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(m_valid && m_data == IDLE_W, "R9", "fill idle when upstream silent", m_data, IDLE_W);
    end
    check(m_valid, "R10", "valid at end", 32'(m_valid), 1);
    finish_run();
  end
endmodule